// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block takes received Ethernet frames as a byte stream and writes them into memory buffers that software hands over through a ring of descriptors. Each descriptor is two 32-bit words: a buffer address word, then a status word. Each buffer holds a fixed number of bytes (128 by default). A frame longer than one buffer continues in the following descriptors. When the last descriptor of the ring is used up, the block goes back to the ring base, even in the middle of a frame.

For each buffer, the block reads the address word at the current descriptor pointer. If software still owns the buffer, the block fills it with frame bytes packed little-endian into 32-bit words. It then writes the status word, and after that it rewrites the address word with the ownership bit set. If the descriptor it needs is still in use, the block signals that no buffer was available and discards the rest of the frame. Address match and broadcast flags arrive on the stream from an external filter and are recorded in the status word of the final buffer.

The frame stream uses a valid/ready handshake. The producer holds `s_data`, `s_sof`, `s_eof` and the flags stable while `s_valid` is high, until `s_ready` is high at a clock edge. `s_ready` drops whenever a memory access is pending, so the producer must tolerate arbitrary stalls. The memory port is a request/acknowledge port. Every request stays stable until `mem_ack` is high at a clock edge, and read data is valid in the cycle that carries `mem_ack`.

Top module: `rx_ring_writer`

## Requirements
- R1: At the start of a frame, the block reads the address word at the current descriptor pointer. The pointer starts at `ring_base` with bits 2:0 cleared and advances by 8 bytes for each buffer that is finished.
- R2: Frame bytes are written to the buffer address taken from the address word with bits 1:0 cleared. Byte k of a buffer lands at byte offset k, in lane k mod 4 of the 32-bit word (bits 8*(k mod 4)+7 : 8*(k mod 4)). The final word of a frame has its unused upper lanes written as zero, and no word beyond it is written.
- R3: A buffer takes exactly 128 bytes. Byte 128 of a frame, and each later byte, continues in the next descriptor's buffer at offset (index mod 128).
- R4: Status word, with all other bits zero:
  - The first buffer of a frame has bit 14 set.
  - The last buffer of a frame has bit 15 set and the frame length in bits 11:0.
  - A frame that fits in one buffer has both bit 14 and bit 15 set.
  - A middle buffer gets a status word of zero.
- R5: The flags in the last buffer's status word are taken with the end-of-frame byte:
  - broadcast in bit 31;
  - address hits 1 to 4 (`s_addr_hit[0]` to `[3]`) in bits 26, 25, 24 and 23;
  - type match in bit 22.
  No other buffer carries these flags.
- R6: A buffer is finished in a fixed order. The status word (descriptor address + 4) is written first. Then the address word is written back with bit 0 set and all its other bits unchanged.
- R7: A descriptor whose address word has bit 1 set is the last in the ring. The next descriptor after it is the ring base, and this also applies in the middle of a frame.
- R8: If a descriptor read for a new buffer has bit 0 set, the block does the following:
  - pulses `bna_pulse` for one cycle;
  - accepts and discards the rest of the frame up to its end byte;
  - writes nothing for that descriptor and leaves the pointer on it.
  Buffers already finished for that frame keep their status.
- R9: While `rx_en` is low, `s_ready` and `mem_req` are low and the descriptor pointer returns to `ring_base`, so the next frame after re-enabling uses the first descriptor.
- R10: Between frames, bytes without the start marker are accepted and discarded with no memory access. `s_ready` is low whenever a memory request is pending, and a memory request is held stable until acknowledged.
- R11: `done_pulse` rises for one cycle after the acknowledged ownership write of a frame's last buffer, and never for a frame dropped under R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low halts the block and rewinds the pointer |
| ring_base | input | 32 | Byte address of the first descriptor |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| s_bcast | input | 1 | Frame has a broadcast destination |
| s_addr_hit | input | 4 | Specific address matches 1 to 4 |
| s_type_hit | input | 1 | Type field match |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| bna_pulse | output | 1 | No buffer available; frame dropped |
| done_pulse | output | 1 | Frame fully written and handed over |

## Verification
The bench sweeps frame lengths around every word-lane residue and across the 128-byte buffer edge. A wrong lane pointer would scramble bytes or leave stale data in the tail word. An off-by-one at the boundary would write byte 128 into the first buffer or open an empty extra buffer. A frame is also driven across the ring wrap and then into a descriptor still owned elsewhere. A design that ignored the wrap bit would write past the ring, and one that checked ownership only at frame start would overwrite a busy buffer. A further case rewinds the pointer through a disable: if the rewind were missing, the next frame would land in the second descriptor.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  // Status word field positions; software decodes these.
  localparam int OWN_BIT   = 0;
  localparam int LAST_BIT  = 1;
  localparam int SOF_BIT   = 14;
  localparam int EOF_BIT   = 15;
  localparam int TYPE_BIT  = 22;
  localparam int HIT1_BIT  = 26;
  localparam int BCAST_BIT = 31;
  localparam int LEN_W     = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RECV,
    ST_WDATA,
    ST_WSTAT,
    ST_WOWN,
    ST_DROP
  } rx_state_e;

  typedef struct packed {
    logic       bcast;
    logic [3:0] hit;
    logic       type_hit;
  } rx_flags_t;

  function automatic logic [31:0] make_status(input logic first, input logic last,
                                              input logic [LEN_W-1:0] len,
                                              input rx_flags_t f);
    logic [31:0] s;
    s = '0;
    s[SOF_BIT] = first;
    if (last) begin
      s[EOF_BIT]       = 1'b1;
      s[LEN_W-1:0]     = len;
      s[BCAST_BIT]     = f.bcast;
      s[TYPE_BIT]      = f.type_hit;
      for (int i = 0; i < 4; i++) s[HIT1_BIT-i] = f.hit[i];
    end
    return s;
  endfunction

endpackage

// File: rtl/rxdma_lane_packer.sv
module rxdma_lane_packer #(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]               din,
  output logic [8*LANES-1:0]       word
);
  localparam int LW = $clog2(LANES);

  // Writing lane 0 starts a fresh word, so unused upper lanes read as zero.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (push) begin
        if (lane == LW'(g)) q <= din;
        else if (lane == '0) q <= '0;
      end
    end
    assign word[8*g +: 8] = q;
  end

endmodule

// File: rtl/rxdma_desc_ptr.sv
module rxdma_desc_ptr #(
  parameter int DESC_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic [31:0] base,
  input  logic        advance,
  input  logic        to_base,
  output logic [31:0] ptr
);
  localparam int AL = $clog2(DESC_BYTES);

  logic [31:0] base_al;
  assign base_al = {base[31:AL], AL'(0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (!rx_en)  ptr <= base_al;
    else if (advance) ptr <= to_base ? base_al : ptr + 32'(DESC_BYTES);
  end

endmodule

// File: rtl/rxdma_ring_ctrl.sv
module rxdma_ring_ctrl
  import rxdma_pkg::*;
#(
  parameter int BUF_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        s_valid,
  input  logic        s_sof,
  input  logic        s_eof,
  input  rx_flags_t   s_flags,
  output logic        s_ready,
  output logic        pk_push,
  output logic [1:0]  pk_lane,
  input  logic [31:0] pk_word,
  input  logic [31:0] ptr,
  output logic        ptr_adv,
  output logic        ptr_to_base,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        bna_pulse,
  output logic        done_pulse
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  rx_state_e        st;
  logic [29:0]      buf_w;
  logic [31:0]      desc_w;
  logic             last_desc;
  logic             first_buf;
  logic             frame_end;
  logic [OFF_W-1:0] boff;
  logic [LEN_W-1:0] flen;
  rx_flags_t        flg;
  logic [31:0]      wr_addr;
  logic             take;
  logic             req_raw;

  assign s_ready = rx_en && ((st == ST_RECV) || (st == ST_DROP) ||
                             ((st == ST_IDLE) && !s_sof));
  assign take    = s_valid && s_ready;
  assign pk_push = take && (st == ST_RECV);
  assign pk_lane = boff[1:0];

  always_comb begin
    req_raw   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    case (st)
      ST_FETCH: req_raw = 1'b1;
      ST_WDATA: begin
        req_raw   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wr_addr;
        mem_wdata = pk_word;
      end
      ST_WSTAT: begin
        req_raw   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr + 32'd4;
        mem_wdata = make_status(first_buf, frame_end, flen, frame_end ? flg : '0);
      end
      ST_WOWN: begin
        req_raw   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = desc_w | 32'(1 << OWN_BIT);
      end
      default: ;
    endcase
  end

  assign mem_req     = rx_en && req_raw;
  assign ptr_adv     = rx_en && (st == ST_WOWN) && mem_ack;
  assign ptr_to_base = last_desc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      buf_w      <= '0;
      desc_w     <= '0;
      last_desc  <= 1'b0;
      first_buf  <= 1'b0;
      frame_end  <= 1'b0;
      boff       <= '0;
      flen       <= '0;
      flg        <= '0;
      wr_addr    <= '0;
      bna_pulse  <= 1'b0;
      done_pulse <= 1'b0;
    end else if (!rx_en) begin
      st         <= ST_IDLE;
      bna_pulse  <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      bna_pulse  <= 1'b0;
      done_pulse <= 1'b0;
      case (st)
        ST_IDLE: if (s_valid && s_sof) begin
          st        <= ST_FETCH;
          first_buf <= 1'b1;
          frame_end <= 1'b0;
          flen      <= '0;
          flg       <= '0;
        end
        ST_FETCH: if (mem_ack) begin
          if (mem_rdata[OWN_BIT]) begin
            bna_pulse <= 1'b1;
            st        <= ST_DROP;
          end else begin
            desc_w    <= mem_rdata;
            buf_w     <= mem_rdata[31:2];
            last_desc <= mem_rdata[LAST_BIT];
            boff      <= '0;
            st        <= ST_RECV;
          end
        end
        ST_RECV: if (take) begin
          boff    <= boff + 1'b1;
          flen    <= flen + 1'b1;
          wr_addr <= {buf_w, 2'b00} + 32'({boff[OFF_W-1:2], 2'b00});
          if (s_eof) begin
            frame_end <= 1'b1;
            flg       <= s_flags;
          end
          if ((boff[1:0] == 2'b11) || s_eof) st <= ST_WDATA;
        end
        ST_WDATA: if (mem_ack) begin
          // boff wrapped to zero means the buffer just filled up.
          st <= (frame_end || (boff == '0)) ? ST_WSTAT : ST_RECV;
        end
        ST_WSTAT: if (mem_ack) st <= ST_WOWN;
        ST_WOWN: if (mem_ack) begin
          first_buf <= 1'b0;
          if (frame_end) begin
            done_pulse <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            st <= ST_FETCH;
          end
        end
        ST_DROP: if (take && s_eof) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxdma_pkg::*;
#(
  parameter int BUF_BYTES  = 128,
  parameter int DESC_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic [31:0] ring_base,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_sof,
  input  logic        s_eof,
  input  logic        s_bcast,
  input  logic [3:0]  s_addr_hit,
  input  logic        s_type_hit,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        bna_pulse,
  output logic        done_pulse
);
  localparam int WORD_LANES = 4;

  rx_flags_t   flags;
  logic        pk_push;
  logic [1:0]  pk_lane;
  logic [31:0] pk_word;
  logic [31:0] ptr;
  logic        ptr_adv;
  logic        ptr_to_base;

  assign flags = '{bcast: s_bcast, hit: s_addr_hit, type_hit: s_type_hit};

  rxdma_lane_packer #(.LANES(WORD_LANES)) u_pack (
    .clk  (clk),
    .rst_n(rst_n),
    .push (pk_push),
    .lane (pk_lane),
    .din  (s_data),
    .word (pk_word)
  );

  rxdma_desc_ptr #(.DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_en  (rx_en),
    .base   (ring_base),
    .advance(ptr_adv),
    .to_base(ptr_to_base),
    .ptr    (ptr)
  );

  rxdma_ring_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .s_valid    (s_valid),
    .s_sof      (s_sof),
    .s_eof      (s_eof),
    .s_flags    (flags),
    .s_ready    (s_ready),
    .pk_push    (pk_push),
    .pk_lane    (pk_lane),
    .pk_word    (pk_word),
    .ptr        (ptr),
    .ptr_adv    (ptr_adv),
    .ptr_to_base(ptr_to_base),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .bna_pulse  (bna_pulse),
    .done_pulse (done_pulse)
  );

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        s_valid,
  input logic        s_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic [31:0] mem_rdata,
  input logic        bna_pulse,
  input logic        done_pulse
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !rx_en)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_wdata)));

  // R10
  no_take_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> !mem_req);

  // R2
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R9
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_en || !mem_req));

  // R8
  bna_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bna_pulse |-> ($past(mem_req && !mem_we && mem_ack && mem_rdata[0]) && !mem_req));

  // R11
  done_after_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(mem_req && mem_we && mem_ack && mem_wdata[0]));

  // R8
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bna_pulse, done_pulse}));

endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (.*);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  localparam int NDESC  = 4;
  localparam int RB     = 32'h40;
  localparam int RBW    = RB / 4;
  localparam int BUFB   = 32'h200;
  localparam int MWORDS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [31:0] ring_base = 32'(RB);
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_sof = 1'b0;
  logic        s_eof = 1'b0;
  logic        s_bcast = 1'b0;
  logic [3:0]  s_addr_hit = '0;
  logic        s_type_hit = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        bna_pulse, done_pulse;

  logic [31:0] mem [0:MWORDS-1];
  logic [31:0] exp_m [0:MWORDS-1];
  logic        fill_req = 1'b0;
  logic        poke_en = 1'b0;
  logic [8:0]  poke_a = '0;
  logic [31:0] poke_d = '0;

  int errors = 0, checks = 0;
  int done_cnt = 0, bna_cnt = 0;
  int exp_ptr = 0;
  bit used [NDESC];

  always #4 clk = ~clk;

  rx_ring_writer u0 (.*);

  // memory model: one-cycle acknowledged word access
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (fill_req) begin
      for (int i = 0; i < MWORDS; i++) mem[i] <= 32'hA5000000 | 32'(i);
    end else if (poke_en) begin
      mem[poke_a] <= poke_d;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[10:2]];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pulse) done_cnt <= done_cnt + 1;
      if (bna_pulse)  bna_cnt  <= bna_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] orig_addr(input int i);
    return 32'(BUFB + 128 * i) | ((i == NDESC - 1) ? 32'd2 : 32'd0);
  endfunction

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'(seed * 13 + i * 7 + (i >> 3));
  endfunction

  function automatic string class_tag(input int w);
    if (w >= RBW && w < RBW + 2 * NDESC) return ((w - RBW) % 2 == 0) ? "R6" : "R4";
    if (w >= BUFB / 4 && w < BUFB / 4 + 32 * NDESC) return "R2";
    return "R8";
  endfunction

  task automatic poke(input int w, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = 9'(w); poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic reclaim_all();
    for (int i = 0; i < NDESC; i++) begin
      poke(RBW + 2 * i, orig_addr(i));
      used[i] = 1'b0;
    end
  endtask

  task automatic send_frame(input int len, input int seed, input logic bc,
                            input logic [3:0] hit, input logic th);
    logic hs;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = byte_of(seed, i);
      s_sof = (i == 0); s_eof = (i == len - 1);
      s_bcast = bc; s_addr_hit = hit; s_type_hit = th;
      forever begin
        #1 hs = s_ready;
        @(posedge clk);
        if (hs) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic run_frame(input int len, input int seed, input logic bc,
                           input logic [3:0] hit, input logic th, input string tag);
    int rem, pos, idx, b, n, w, d0, b0;
    bit bna_exp;
    logic [31:0] st;
    for (int i = 0; i < MWORDS; i++) exp_m[i] = mem[i];
    rem = len; pos = 0; idx = exp_ptr; b = 0; bna_exp = 0;
    while (rem > 0) begin
      if (used[idx]) begin bna_exp = 1; break; end
      n = (rem > 128) ? 128 : rem;
      for (int j = 0; j < n; j++) begin
        w = (BUFB + 128 * idx + j) / 4;
        if (j % 4 == 0) exp_m[w] = '0;
        exp_m[w][8 * (j % 4) +: 8] = byte_of(seed, pos + j);
      end
      st = (b == 0) ? 32'h4000 : 32'h0;
      if (rem <= 128)
        st = st | 32'h8000 | 32'(len & 12'hFFF) | (32'(bc) << 31) |
             (32'(hit[0]) << 26) | (32'(hit[1]) << 25) | (32'(hit[2]) << 24) |
             (32'(hit[3]) << 23) | (32'(th) << 22);
      exp_m[RBW + 2 * idx + 1] = st;
      exp_m[RBW + 2 * idx]     = orig_addr(idx) | 32'd1;
      used[idx] = 1'b1;
      idx = (idx + 1) % NDESC; rem -= n; pos += n; b++;
    end
    exp_ptr = idx;
    d0 = done_cnt; b0 = bna_cnt;
    send_frame(len, seed, bc, hit, th);
    repeat (20) @(negedge clk);
    // R11: completion pulse only for a fully stored frame
    chk((done_cnt - d0) == (bna_exp ? 0 : 1), "R11", {tag, " done pulses"},
        32'(done_cnt - d0), bna_exp ? 32'd0 : 32'd1);
    // R8: no-buffer pulse exactly when a busy descriptor is met
    chk((bna_cnt - b0) == (bna_exp ? 1 : 0), "R8", {tag, " bna pulses"},
        32'(bna_cnt - b0), bna_exp ? 32'd1 : 32'd0);
    for (int i = 0; i < MWORDS; i++)
      chk(mem[i] === exp_m[i], class_tag(i), $sformatf("%s len=%0d word %0d", tag, len, i),
          mem[i], exp_m[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    for (int i = 0; i < NDESC; i++) begin
      poke(RBW + 2 * i, orig_addr(i));
      poke(RBW + 2 * i + 1, 32'h0);
      used[i] = 1'b0;
    end
    @(negedge clk);
    // R9: reset state, block disabled
    chk(s_ready === 1'b0, "R9", "s_ready in reset", 32'(s_ready), 32'd0);
    chk(mem_req === 1'b0, "R9", "mem_req in reset", 32'(mem_req), 32'd0);
    chk(bna_pulse === 1'b0 && done_pulse === 1'b0, "R11", "pulses in reset",
        {30'd0, bna_pulse, done_pulse}, 32'd0);
    rst_n = 1'b1;
    s_valid = 1'b1; s_sof = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(s_ready === 1'b0 && mem_req === 1'b0, "R9", "disabled with pending sof",
          {30'd0, s_ready, mem_req}, 32'd0);
    end
    s_valid = 1'b0; s_sof = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);

    // R10: stray bytes between frames are taken and dropped
    for (int i = 0; i < MWORDS; i++) exp_m[i] = mem[i];
    s_valid = 1'b1; s_data = 8'h77;
    repeat (3) begin
      #1 chk(s_ready === 1'b1, "R10", "stray byte accepted", 32'(s_ready), 32'd1);
      chk(mem_req === 1'b0, "R10", "no access for stray byte", 32'(mem_req), 32'd0);
      @(negedge clk);
    end
    s_valid = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < MWORDS; i++)
      chk(mem[i] === exp_m[i], "R10", $sformatf("stray bytes word %0d", i), mem[i], exp_m[i]);

    run_frame(5, 3, 1'b1, 4'b0000, 1'b0, "R1 short");
    run_frame(128, 11, 1'b0, 4'b1010, 1'b1, "R4 exact");
    // R5: flag field of the last status word
    chk(mem[RBW + 3][31:22] === 10'b0000001011, "R5", "flags in last status",
        32'(mem[RBW + 3][31:22]), 32'h00B);
    run_frame(200, 20, 1'b1, 4'b0001, 1'b0, "R7 wrap");
    // R5: a first, non-last buffer carries no flags
    chk(mem[RBW + 5] === 32'h4000, "R5", "first buffer status", mem[RBW + 5], 32'h4000);
    run_frame(10, 5, 1'b0, 4'b0000, 1'b0, "R8 busy start");
    reclaim_all();
    run_frame(129, 33, 1'b0, 4'b0100, 1'b1, "R3 spill");
    run_frame(300, 44, 1'b1, 4'b1111, 1'b1, "R8 busy midframe");
    reclaim_all();
    run_frame(3, 9, 1'b0, 4'b0000, 1'b0, "R2 tail");

    // R9: disabling rewinds the pointer to the ring base
    rx_en = 1'b0;
    s_valid = 1'b1; s_sof = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(s_ready === 1'b0 && mem_req === 1'b0, "R9", "disabled mid-run",
          {30'd0, s_ready, mem_req}, 32'd0);
    end
    s_valid = 1'b0; s_sof = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    exp_ptr = 0;
    reclaim_all();
    run_frame(64, 61, 1'b0, 4'b0010, 1'b0, "R9 rewind");

    // R2/R3: sweep every lane residue and the buffer boundary
    for (int l = 1; l <= 12; l++) begin
      reclaim_all();
      run_frame(l, l, 1'(l), 4'(l), 1'(l >> 1), "R2 sweep");
    end
    for (int l = 124; l <= 132; l++) begin
      reclaim_all();
      run_frame(l, l, 1'(l), 4'(l), 1'(l >> 1), "R3 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule